// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns a single request for an external bus transaction into the pin-level timing of a processor bus whose low byte is shared between address and data. A requester presents a cycle kind (opcode fetch, memory read, memory write, I/O read or I/O write), a 16-bit address and, for writes, a data byte. The sequencer then steps through the T-states of that cycle. Each T-state lasts `CLK_PER_T` clocks.

During T1 the sequencer drives the low address byte on the shared lines and raises an address latch enable pulse, so that an external latch can capture and split off the low address. The high address byte stays on its own output-only lines for the whole cycle. In T2 and T3 the shared lines either float so that a device can return read data, or carry the write byte. Active-low read or write strobes are asserted at the same time. The captured read byte is returned when the cycle ends. An opcode fetch adds a fourth T-state, in which the bus is quiet while the core decodes.

A status triple (an I/O-or-memory select plus two status bits) identifies the cycle kind for its whole length. Four separate active-low strobes are decoded from the select and the read/write strobes: memory read, memory write, I/O read and I/O write. All pin outputs come directly from flip-flops.

Top module: `mbus_cycle_seq`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0, `ale` and `ad_oe` are 0, and `rd_n`, `wr_n`, `memr_n`, `memw_n`, `ior_n` and `iow_n` are all 1.
- R2: A request is accepted only when `busy` is 0 and `req_valid` is 1 with a `req_kind` code of 0 (opcode fetch), 1 (memory read), 2 (memory write), 3 (I/O read) or 4 (I/O write). Codes 5 to 7, and any request made while `busy` is 1, are ignored, and the outputs stay as they were.
- R3: For the whole cycle, {`io_m`,`s1`,`s0`} is 011 for an opcode fetch, 010 for a memory read, 001 for a memory write, 110 for an I/O read and 101 for an I/O write. It is 000 when idle.
- R4: An opcode fetch lasts 4 T-states and every other kind lasts 3. Each T-state lasts `CLK_PER_T` clocks. `busy` is 1 for exactly that many clocks starting the clock after acceptance. `done` is 1 for the single clock after the cycle ends.
- R5: In T1, `ad_oe` is 1 and `ad_out` carries address bits 7:0. `ale` is 1 only in the first half of T1 (the first `CLK_PER_T/2` clocks) and is 0 at all other times.
- R6: `a_hi` carries address bits 15:8 in every clock of the cycle and is 0 when idle.
- R7: In T2 and T3 of a read kind (codes 0, 1 and 3), `rd_n` is 0, `ad_oe` is 0 and `wr_n` is 1.
- R8: In T2 and T3 of a write kind (codes 2 and 4), `wr_n` is 0, `ad_oe` is 1, `ad_out` carries the write byte and `rd_n` is 1.
- R9: `rdata` takes the value of `ad_in` sampled at the end of T3 of a read kind. Changes on `ad_in` after that point, including during T4 of a fetch, do not alter it.
- R10: `memr_n` = `io_m` OR `rd_n`, `memw_n` = `io_m` OR `wr_n`, `ior_n` = NOT `io_m` OR `rd_n`, and `iow_n` = NOT `io_m` OR `wr_n`. At most one of these four is low at a time.
- R11: In T4 of an opcode fetch, `rd_n` and `wr_n` are 1, `ad_oe` is 0 and `ale` is 0.
- R12: `rd_n` and `wr_n` are never both 0, and neither is 0 while `ale` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request a bus cycle |
| req_kind | input | 3 | Cycle kind code (0..4) |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock pulse after a cycle ends |
| rdata | output | 8 | Byte captured at end of T3 of a read |
| a_hi | output | 8 | High address byte lines |
| ad_out | output | 8 | Shared low address/data lines, outgoing value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 8 | Shared low lines, incoming value |
| ale | output | 1 | Address latch enable |
| io_m | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |

## Verification
Some properties are checked on every clock: read and write strobes never overlap, neither strobe is asserted while `ale` is high, the shared lines float whenever `rd_n` is low, at most one decoded strobe is active, and the status triple holds steady across a cycle. Other behaviours can only be shown by the bench's scenarios, because they depend on what was requested. These are the status value for each kind, the exact clock on which each strobe and `ale` edge appears, the length of a fetch compared with the other kinds, the address and write byte on the pins, the byte captured at the end of T3 even when the bus changes during T4, and requests that are rejected or made mid-cycle.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4
  } kind_e;

  // {io_m, s1, s0} per cycle kind
  function automatic logic [2:0] status_of(kind_e k);
    case (k)
      K_FETCH: return 3'b011;
      K_MRD:   return 3'b010;
      K_MWR:   return 3'b001;
      K_IORD:  return 3'b110;
      K_IOWR:  return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic is_write(kind_e k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction

  function automatic logic [2:0] last_t(kind_e k);
    return (k == K_FETCH) ? 3'd4 : 3'd3;
  endfunction

  function automatic logic code_ok(logic [2:0] c);
    return c <= 3'd4;
  endfunction
endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int CLK_PER_T = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_valid,
  input  logic [2:0]                        req_kind,
  output logic                              accept,
  output logic [2:0]                        nxt_t,
  output logic [$clog2(CLK_PER_T)-1:0]      nxt_ph,
  output kind_e                             nxt_kind,
  output logic                              cap_en,
  output logic                              fin
);
  localparam int PH_W = $clog2(CLK_PER_T);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_PER_T - 1);

  logic [2:0]      t_q;      // 0 = idle, 1..4 = T-state
  logic [PH_W-1:0] ph_q;
  kind_e           kind_q;

  assign accept   = (t_q == 3'd0) && req_valid && code_ok(req_kind);
  assign nxt_kind = accept ? kind_e'(req_kind) : kind_q;
  assign fin      = (t_q != 3'd0) && (ph_q == PH_LAST) && (t_q == last_t(kind_q));
  assign cap_en   = (t_q == 3'd3) && (ph_q == PH_LAST) && !is_write(kind_q);

  always_comb begin
    nxt_t  = t_q;
    nxt_ph = ph_q;
    if (t_q == 3'd0) begin
      if (accept) begin
        nxt_t  = 3'd1;
        nxt_ph = '0;
      end
    end else if (ph_q == PH_LAST) begin
      nxt_ph = '0;
      nxt_t  = fin ? 3'd0 : t_q + 3'd1;
    end else begin
      nxt_ph = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q    <= 3'd0;
      ph_q   <= '0;
      kind_q <= K_FETCH;
    end else begin
      t_q    <= nxt_t;
      ph_q   <= nxt_ph;
      kind_q <= nxt_kind;
    end
  end

  AST_FOURTH_ONLY_FETCH: assert property (@(posedge clk) disable iff (rst)
    (t_q == 3'd4) |-> (kind_q == K_FETCH)); // R4
  AST_FIN_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    fin |=> (t_q == 3'd0)); // R4
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (t_q != 3'd0) |-> !accept); // R2
endmodule

// File: rtl/mbus_pins.sv
module mbus_pins
  import mbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int CLK_PER_T = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          accept,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  input  logic [2:0]                    nxt_t,
  input  logic [$clog2(CLK_PER_T)-1:0]  nxt_ph,
  input  kind_e                         nxt_kind,
  output logic                          busy,
  output logic [ADDR_W-DATA_W-1:0]      a_hi,
  output logic [DATA_W-1:0]             ad_out,
  output logic                          ad_oe,
  output logic                          ale,
  output logic                          io_m,
  output logic                          s1,
  output logic                          s0,
  output logic                          rd_n,
  output logic                          wr_n,
  output logic                          memr_n,
  output logic                          memw_n,
  output logic                          ior_n,
  output logic                          iow_n
);
  localparam int PH_W = $clog2(CLK_PER_T);
  localparam logic [PH_W-1:0] ALE_END = PH_W'(CLK_PER_T / 2);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addr_q, addr_use;
  logic [DATA_W-1:0] wd_q, wd_use;

  logic            n_busy, n_ale, n_oe, n_rd, n_wr;
  logic [DATA_W-1:0] n_ad;
  logic [HI_W-1:0] n_hi;
  logic [2:0]      n_st;

  assign addr_use = accept ? req_addr  : addr_q;
  assign wd_use   = accept ? req_wdata : wd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      wd_q   <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      wd_q   <= req_wdata;
    end
  end

  always_comb begin
    n_busy = (nxt_t != 3'd0);
    n_ale  = 1'b0;
    n_oe   = 1'b0;
    n_ad   = '0;
    n_rd   = 1'b1;
    n_wr   = 1'b1;
    n_hi   = '0;
    n_st   = 3'b000;
    if (n_busy) begin
      n_hi = addr_use[ADDR_W-1:DATA_W];
      n_st = status_of(nxt_kind);
      if (nxt_t == 3'd1) begin
        n_oe  = 1'b1;
        n_ad  = addr_use[DATA_W-1:0];
        n_ale = (nxt_ph < ALE_END);
      end else if ((nxt_t == 3'd2) || (nxt_t == 3'd3)) begin
        if (is_write(nxt_kind)) begin
          n_oe = 1'b1;
          n_ad = wd_use;
          n_wr = 1'b0;
        end else begin
          n_rd = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      a_hi   <= '0;
      ad_out <= '0;
      ad_oe  <= 1'b0;
      ale    <= 1'b0;
      {io_m, s1, s0} <= 3'b000;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      memr_n <= 1'b1;
      memw_n <= 1'b1;
      ior_n  <= 1'b1;
      iow_n  <= 1'b1;
    end else begin
      busy   <= n_busy;
      a_hi   <= n_hi;
      ad_out <= n_ad;
      ad_oe  <= n_oe;
      ale    <= n_ale;
      {io_m, s1, s0} <= n_st;
      rd_n   <= n_rd;
      wr_n   <= n_wr;
      memr_n <= n_st[2]  | n_rd;
      memw_n <= n_st[2]  | n_wr;
      ior_n  <= ~n_st[2] | n_rd;
      iow_n  <= ~n_st[2] | n_wr;
    end
  end

  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n)); // R12
  AST_ALE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n)); // R12
  AST_ALE_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ale |-> (busy && ad_oe)); // R5
  AST_READ_FLOATS: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe); // R7
  AST_DERIVED_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~{memr_n, memw_n, ior_n, iow_n})); // R10
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable({io_m, s1, s0})); // R3
endmodule

// File: rtl/mbus_capture.sv
module mbus_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic              fin,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= fin;
      if (cap_en) rdata <= ad_in;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4
endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int CLK_PER_T = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [2:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     busy,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ale,
  output logic                     io_m,
  output logic                     s1,
  output logic                     s0,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     memr_n,
  output logic                     memw_n,
  output logic                     ior_n,
  output logic                     iow_n
);
  localparam int PH_W = $clog2(CLK_PER_T);

  logic            accept, cap_en, fin;
  logic [2:0]      nxt_t;
  logic [PH_W-1:0] nxt_ph;
  kind_e           nxt_kind;

  mbus_seq #(.CLK_PER_T(CLK_PER_T)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .accept(accept), .nxt_t(nxt_t), .nxt_ph(nxt_ph), .nxt_kind(nxt_kind),
    .cap_en(cap_en), .fin(fin)
  );

  mbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_PER_T(CLK_PER_T)) u_pins (
    .clk(clk), .rst(rst), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .nxt_t(nxt_t), .nxt_ph(nxt_ph), .nxt_kind(nxt_kind),
    .busy(busy), .a_hi(a_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale),
    .io_m(io_m), .s1(s1), .s0(s0), .rd_n(rd_n), .wr_n(wr_n),
    .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n)
  );

  mbus_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .cap_en(cap_en), .fin(fin), .ad_in(ad_in),
    .rdata(rdata), .done(done)
  );
endmodule

// File: tb/mbus_cycle_seq_test.sv
module mbus_cycle_seq_test;
  logic clk = 1'b0;
  logic rst;
  logic req_valid;
  logic [2:0] req_kind;
  logic [15:0] req_addr;
  logic [7:0] req_wdata, ad_in;
  logic busy, done, ad_oe, ale, io_m, s1, s0, rd_n, wr_n;
  logic memr_n, memw_n, ior_n, iow_n;
  logic [7:0] rdata, a_hi, ad_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] last_rd = 8'h00;

  always #10 clk = ~clk;

  mbus_cycle_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .a_hi(a_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale(ale), .io_m(io_m), .s1(s1), .s0(s0), .rd_n(rd_n), .wr_n(wr_n),
    .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_status(int kind);
    case (kind)
      0: return 3'b011;
      1: return 3'b010;
      2: return 3'b001;
      3: return 3'b110;
      default: return 3'b101;
    endcase
  endfunction

  function automatic bit kind_wr(int kind);
    return kind == 2 || kind == 4;
  endfunction

  // {ale, oe, ad, rd_n, wr_n} for clock k of a cycle (2 clocks per T-state)
  function automatic logic [11:0] exp_bus(int kind, logic [15:0] a, logic [7:0] wd, int k);
    int t = k / 2 + 1;
    bit mid = (t == 2 || t == 3);
    bit al = (t == 1) && (k % 2 == 0);
    bit oe = (t == 1) || (kind_wr(kind) && mid);
    logic [7:0] v = (t == 1) ? a[7:0] : (oe ? wd : 8'h00);
    bit rn = !(!kind_wr(kind) && mid);
    bit wn = !(kind_wr(kind) && mid);
    return {al, oe, v, rn, wn};
  endfunction

  task automatic run_cycle(int kind, logic [15:0] a, logic [7:0] wd, logic [7:0] rv, bit stray);
    int n = (kind == 0) ? 8 : 6;
    string bt;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'(kind); req_addr = a; req_wdata = wd; ad_in = rv;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      int t = k / 2 + 1;
      logic [11:0] e = exp_bus(kind, a, wd, k);
      logic [2:0] st = exp_status(kind);
      bt = (t == 1) ? "R5 T1 pins" : (t == 4) ? "R11 T4 pins" :
           kind_wr(kind) ? "R8 write pins" : "R7 read pins";
      check(bt, {ale, ad_oe, ad_out & {8{ad_oe}}, rd_n, wr_n}, e);
      check("R3 status", {io_m, s1, s0}, st);
      check("R6 high address", a_hi, a[15:8]);
      check("R4 busy in cycle", busy, 1'b1);
      check("R10 decoded strobes", {memr_n, memw_n, ior_n, iow_n},
            {st[2] | e[1], st[2] | e[0], ~st[2] | e[1], ~st[2] | e[0]});
      // R2: a request during the cycle must be ignored
      if (stray && k == 1) begin
        req_valid = 1'b1; req_kind = 3'(kind_wr(kind) ? 1 : 4);
        req_addr = ~a; req_wdata = ~wd;
      end
      if (stray && k == 2) req_valid = 1'b0;
      if (kind == 0 && k == 6) ad_in = ~rv;  // R9: bus changes in T4
      @(negedge clk);
    end
    check("R4 idle after cycle", busy, 1'b0);
    check("R4 done pulse", done, 1'b1);
    check("R6 idle high address", a_hi, 8'h00);
    if (!kind_wr(kind)) last_rd = rv;
    check("R9 read data", rdata, last_rd);
    @(negedge clk);
    check("R4 done one clock", done, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; req_valid = 1'b0; req_kind = 3'd0; req_addr = 16'h0;
    req_wdata = 8'h0; ad_in = 8'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset busy/done/ale/oe", {busy, done, ale, ad_oe}, 4'b0000);
    check("R1 reset strobes", {rd_n, wr_n, memr_n, memw_n, ior_n, iow_n}, 6'b111111);

    // directed cases
    run_cycle(0, 16'h2005, 8'h00, 8'h4F, 0);
    run_cycle(1, 16'h2001, 8'h00, 8'h32, 0);
    run_cycle(2, 16'hFFFF, 8'hA5, 8'h11, 0);
    run_cycle(3, 16'h0000, 8'h00, 8'hC3, 0);
    run_cycle(4, 16'h00FE, 8'h5A, 8'h22, 0);
    run_cycle(0, 16'h8001, 8'h00, 8'h99, 1);
    run_cycle(2, 16'h1234, 8'h77, 8'h00, 1);

    // R2: unused codes are ignored
    for (int c = 5; c < 8; c++) begin
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'(c); req_addr = 16'hBEEF; req_wdata = 8'h42;
      @(negedge clk);
      req_valid = 1'b0;
      check("R2 bad code ignored", {busy, ale, ad_oe, rd_n, wr_n, io_m, s1, s0},
            8'b00011000);
      @(negedge clk);
      check("R2 bad code no done", {busy, done, rdata}, {2'b00, last_rd});
    end

    // random mix
    for (int i = 0; i < 60; i++) begin
      int kind = int'($urandom % 5);
      run_cycle(kind, 16'($urandom), 8'($urandom), 8'($urandom), ($urandom % 4) == 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule